// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits between a bus requester and the external cycle sequencer. It records the direction (read or write) and chip-select area of the most recently granted access. It then holds off the grant for the next request until enough idle bus cycles have passed since the previous access ended. The number of idle cycles needed depends on the kind of transition.

- After any write, one delay applies whatever comes next.
- After a read, the delay depends on whether the next access is a read or a write.
- Each of the two read cases has one value for the same area and another for a different area.

All five delays are 3-bit fields of one 32-bit control word. The sequencer marks the last cycle of each access with a one-cycle done pulse. Idle cycles are counted from the cycle after that pulse, and the grant is given once the count reaches the selected delay. The requester keeps its request asserted until it sees the grant. The grant lasts one cycle and is combinational from the request.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset nothing is remembered, so the first request is granted in the cycle it appears, with no idle cycles.
- R2: Only one access is outstanding at a time. Grant is low from the cycle after a grant until the cycle after the done pulse that ends that access, even while a request is held.
- R3: When the previous access was a write, the next request waits the number of idle cycles in control-word bits 30:28, for either direction and either area.
- R4: Previous read, next write, different area: the wait comes from bits 26:24.
- R5: Previous read, next write, same area: the wait comes from bits 22:20.
- R6: Previous read, next read, different area: the wait comes from bits 18:16.
- R7: Previous read, next read, same area: the wait comes from bits 14:12. A value of zero grants in the cycle right after the done pulse, so reads run back to back.
- R8: Idle cycles are counted from the cycle after the done pulse, whether or not a request is present. A request that arrives k cycles late waits max(D-k, 0) cycles.
- R9: A done pulse while no access is outstanding is ignored and does not restart the idle count.
- R10: Same area means equality of every bit of the area number. Areas that differ only in the top bit count as different.
- R11: The largest field value, 7, gives exactly 7 idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Delay control word holding the five 3-bit fields |
| reqValid | input | 1 | Request present; held until granted |
| reqWrite | input | 1 | Request direction: 1 = write, 0 = read |
| reqArea | input | AREA_W | Chip-select area number of the request |
| accDone | input | 1 | One-cycle pulse on the last cycle of the granted access |
| grant | output | 1 | One-cycle grant to the requester |

## Verification
The bench runs a chain of accesses that walks every transition class. Each field holds a distinct value (3, 5, 2, 4, 0), so a wrong field selection shows up as a wrong wait count.

Requests that arrive late, with and without a stray done pulse in the gap, separate counting from the done pulse from counting from the request, and show whether the idle count is restarted. Area pairs that differ only in the top bit test the width of the area comparison. A request held across a busy access tests that only one access is outstanding. A reload of the control word with the largest field value tests the top of the counter range.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  localparam int GAP_W   = 3;
  localparam int CFG_W   = 32;
  localparam int WW_LSB  = 28;
  localparam int RWD_LSB = 24;
  localparam int RWS_LSB = 20;
  localparam int RRD_LSB = 16;
  localparam int RRS_LSB = 12;

  typedef enum logic {ST_GAP = 1'b0, ST_BUSY = 1'b1} seqState_t;

  typedef struct packed {
    logic capture;
    logic clearIdle;
    logic countIdle;
  } gapStrobes_t;
endpackage

// File: rtl/idle_gap_datapath.sv
module idle_gap_datapath
  import idle_gap_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CFG_W-1:0]      cfgWord,
  input  logic                  reqWrite,
  input  logic [AREA_W-1:0]     reqArea,
  input  gapStrobes_t           strobes,
  output logic                  delayMet
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              histValid;
  logic              lastWrite;
  logic [AREA_W-1:0] lastArea;
  logic [CNT_W-1:0]  idleCnt;
  logic [GAP_W-1:0]  selDelay;
  logic              sameArea;

  assign sameArea = (lastArea == reqArea);

  always_comb begin
    if (!histValid)
      selDelay = '0;
    else if (lastWrite)
      selDelay = cfgWord[WW_LSB +: GAP_W];
    else if (reqWrite)
      selDelay = sameArea ? cfgWord[RWS_LSB +: GAP_W] : cfgWord[RWD_LSB +: GAP_W];
    else
      selDelay = sameArea ? cfgWord[RRS_LSB +: GAP_W] : cfgWord[RRD_LSB +: GAP_W];
  end

  assign delayMet = (idleCnt >= CNT_W'(selDelay));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histValid <= 1'b0;
      lastWrite <= 1'b0;
      lastArea  <= '0;
    end else if (strobes.capture) begin
      histValid <= 1'b1;
      lastWrite <= reqWrite;
      lastArea  <= reqArea;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      idleCnt <= '0;
    else if (strobes.clearIdle)
      idleCnt <= '0;
    else if (strobes.countIdle && idleCnt != CNT_MAX)
      idleCnt <= idleCnt + 1'b1;
  end

  // R8: idle count only moves up until a real access end clears it
  assert_idle_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearIdle |=> idleCnt >= $past(idleCnt));

  // R10: remembered access changes only on a grant
  assert_history_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(lastWrite) && $stable(lastArea) && $stable(histValid)));

  // R3: a grant is never given before the selected gap has elapsed
  assert_gap_respected_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> idleCnt >= CNT_W'(selDelay));
endmodule

// File: rtl/idle_gap_control.sv
module idle_gap_control
  import idle_gap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        accDone,
  input  logic        delayMet,
  output logic        grant,
  output gapStrobes_t strobes
);
  seqState_t state;

  assign grant = (state == ST_GAP) && reqValid && delayMet;

  always_comb begin
    strobes.capture   = grant;
    strobes.clearIdle = (state == ST_BUSY) && accDone;
    strobes.countIdle = (state == ST_GAP);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      state <= ST_GAP;
    else begin
      case (state)
        ST_GAP:  if (grant)   state <= ST_BUSY;
        ST_BUSY: if (accDone) state <= ST_GAP;
        default: state <= ST_GAP;
      endcase
    end
  end

  // R2: a grant lasts one cycle
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);

  // R2: no grant while an access has not yet ended
  assert_no_grant_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !accDone) |=> !grant);
endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idle_gap_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgWord,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              accDone,
  output logic              grant
);
  gapStrobes_t strobes;
  logic        delayMet;

  idle_gap_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .accDone  (accDone),
    .delayMet (delayMet),
    .grant    (grant),
    .strobes  (strobes)
  );

  idle_gap_datapath #(.AREA_W(AREA_W), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWord  (cfgWord),
    .reqWrite (reqWrite),
    .reqArea  (reqArea),
    .strobes  (strobes),
    .delayMet (delayMet)
  );
endmodule

// File: tb/idle_gap_inserter_tb.sv
module idle_gap_inserter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqArea = '0;
  logic        accDone = 1'b0;
  logic        grant;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  idle_gap_inserter dut_i (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqArea(reqArea), .accDone(accDone), .grant(grant)
  );

  function automatic logic [31:0] mkCfg(int ww, int rwd, int rws, int rrd, int rrs);
    logic [31:0] w = '0;
    w[30:28] = 3'(ww); w[26:24] = 3'(rwd); w[22:20] = 3'(rws);
    w[18:16] = 3'(rrd); w[14:12] = 3'(rrs);
    return w;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Entered at a negedge right after the previous access end was registered.
  task automatic runAccess(string tag, bit wr, int area, int late, bit spur,
                           bit holdReq, int expWait);
    int waits = 0;
    for (int i = 0; i < late; i++) begin
      accDone = spur && (i == 0);
      @(negedge clk);
    end
    accDone = 1'b0;
    reqValid = 1'b1; reqWrite = wr; reqArea = 3'(area);
    #1;
    while (!grant && waits < 20) begin
      @(negedge clk); #1; waits++;
    end
    chk(tag, waits, expWait);
    @(negedge clk);
    reqValid = holdReq;
    for (int i = 0; i < 3; i++) begin
      #1;
      if (holdReq) chk("R2 held request during busy", int'(grant), 0);
      @(negedge clk);
    end
    accDone = 1'b1;
    reqValid = 1'b0;
    #1;
    if (holdReq) chk("R2 no grant in done cycle", int'(grant), 0);
    @(negedge clk);
    accDone = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cfgWord = mkCfg(3, 5, 2, 4, 0);
    repeat (3) @(negedge clk);
    #1; chk("R1 grant low in reset", int'(grant), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1; chk("R1 grant low after reset, no request", int'(grant), 0);
    runAccess("R1 first request no gap", 1'b0, 1, 0, 1'b0, 1'b0, 0);
    runAccess("R7 read-read same area zero", 1'b0, 1, 0, 1'b0, 1'b0, 0);
    runAccess("R6 read-read diff area", 1'b0, 2, 0, 1'b0, 1'b0, 4);
    runAccess("R5 read-write same area", 1'b1, 2, 0, 1'b0, 1'b0, 2);
    runAccess("R3 write-read", 1'b0, 5, 0, 1'b0, 1'b0, 3);
    runAccess("R4 read-write diff area", 1'b1, 6, 0, 1'b0, 1'b1, 5);
    runAccess("R3 write-write same area", 1'b1, 6, 0, 1'b0, 1'b0, 3);
    runAccess("R8 late by 2 after write", 1'b0, 6, 2, 1'b0, 1'b0, 1);
    runAccess("R8 late by 6 after read", 1'b0, 3, 6, 1'b0, 1'b0, 0);
    runAccess("R9 stray done in gap", 1'b1, 3, 1, 1'b1, 1'b0, 1);
    cfgWord = mkCfg(7, 5, 2, 4, 0);
    runAccess("R11 max gap of 7", 1'b0, 3, 0, 1'b0, 1'b0, 7);
    runAccess("R10 areas differ in top bit", 1'b0, 7, 0, 1'b0, 1'b0, 4);
    runAccess("R10 same full area", 1'b0, 7, 0, 1'b0, 1'b0, 0);
    cfgWord = mkCfg(1, 5, 2, 4, 6);
    runAccess("R7 read-read same area nonzero", 1'b0, 7, 0, 1'b0, 1'b0, 6);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule